// File: doc/BRIEF.md
# Reset Cause Hub

This block combines several independent reset requests into one system reset. An asynchronous power-on request resets the block at once. Brown-out, external master clear, software reset, watchdog timeout, configuration mismatch, trap conflict, and three illegal-condition causes (bad opcode, uninitialized working register, security violation) are each passed through a two-flop synchronizer. Any of these holds the system reset. The reset stays asserted for a fixed stretch of clock cycles after the last request goes away, so it is released cleanly on the clock.

Each cause sets its own sticky bit in a 10-bit status word. Software reads the status word in full and can overwrite it in full at any time. A write only changes the recorded values and never starts a reset. The block also sorts each reset into cold (power-on or brown-out) or warm (every other cause). On a cold reset the restart clock selection comes from the configured oscillator field. On a warm reset it comes from the field that names the oscillator currently running.

Top module: `reset_cause_hub`

## Requirements
- R1: When a synchronized cause input goes high, `sysRst` is low after the second rising clock edge and high after the third rising edge, counted from the edge at which the input is first sampled.
- R2: After the last cause input goes low, `sysRst` stays high through STRETCH+1 rising edges and is low after edge STRETCH+2.
- R3: Each cause sets one status bit: bit 0 power-on, bit 1 brown-out, bit 2 illegal opcode, bit 3 uninitialized register, bit 4 watchdog, bit 5 configuration mismatch, bit 6 software reset, bit 7 master clear, bit 8 trap conflict, bit 9 security.
- R4: `porReq` high asserts `sysRst` without waiting for a clock edge and forces the status to 0x003 and `coldReset` to 1. After `porReq` is released, `sysRst` stays high for STRETCH rising edges.
- R5: Status bits are sticky. Unless software writes them, they keep their value across later resets, and several can be set together.
- R6: When `wrEn` is high at a rising edge, the status is loaded from `wrData`, whether or not a reset is in progress. A cause that is active in the same cycle still sets its bit. A write never asserts `sysRst`.
- R7: A brown-out or power-on reset sets `coldReset` to 1, and `clkSel` then equals `cfgOscSel`.
- R8: Any other cause that starts a reset while `sysRst` is low clears `coldReset`, and `clkSel` then equals `curOscSel`.
- R9: A warm cause that arrives while a cold reset is still in progress leaves the reset classified as cold.
- R10: `rdData` always shows the current status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porReq | input | 1 | Power-on request, active high, asynchronous |
| borReq | input | 1 | Brown-out request |
| mclrReq | input | 1 | External master clear request |
| swResetReq | input | 1 | Software reset instruction request |
| wdtReq | input | 1 | Watchdog timeout request |
| cfgMismatchReq | input | 1 | Configuration mismatch request |
| trapReq | input | 1 | Trap conflict request |
| illOpcodeReq | input | 1 | Illegal opcode request |
| uninitRegReq | input | 1 | Uninitialized working register request |
| securityReq | input | 1 | Security violation request |
| wrEn | input | 1 | Status write strobe |
| wrData | input | 10 | Status write value |
| rdData | output | 10 | Current status word |
| cfgOscSel | input | OSC_W | Configured oscillator selection (used on cold reset) |
| curOscSel | input | OSC_W | Running oscillator selection (used on warm reset) |
| clkSel | output | OSC_W | Clock selection that applies at restart |
| coldReset | output | 1 | 1 when the most recent reset was cold |
| sysRst | output | 1 | Combined system reset |

## Verification
On every cycle the assertions check the following: a synchronized request raises the reset one edge later, the reset is still held when the last request falls, every active cause leaves its status bit set, the status does not change when there is neither a write nor a cause, a write with no request never raises the reset, and the cold/warm classification follows the request that started the reset. Only the scenarios can show the exact synchronizer latency and stretch length at the pins, the full cause-to-bit map, the asynchronous power-on values, the write-versus-cause priority, and which oscillator field reaches `clkSel`.

// File: rtl/rstagg_pkg.sv
package rstagg_pkg;
  localparam int NUM_CAUSES = 9;
  localparam int STAT_W     = 10;

  // cause index order: brown-out, master clear, software, watchdog,
  // config mismatch, trap, illegal opcode, uninit register, security
  localparam int BOR_IDX = 0;
  localparam int unsigned CAUSE_BIT [NUM_CAUSES] = '{1, 7, 6, 4, 5, 8, 2, 3, 9};

  localparam logic [STAT_W-1:0] POR_STATUS = 10'h003;

  typedef struct packed {
    logic [STAT_W-1:0] setMask;
    logic              anyReq;
    logic              coldReq;
    logic              inReset;
  } strobe_t;
endpackage

// File: rtl/rstagg_sync2.sv
module rstagg_sync2 #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             arst,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      stage1 <= '0;
      dOut   <= '0;
    end else begin
      stage1 <= dIn;
      dOut   <= stage1;
    end
  end
endmodule

// File: rtl/rstagg_ctrl.sv
module rstagg_ctrl
  import rstagg_pkg::*;
#(
  parameter int STRETCH = 4
) (
  input  logic                  clk,
  input  logic                  porReq,
  input  logic [NUM_CAUSES-1:0] causeReq,
  output strobe_t               strobes,
  output logic                  sysRst
);
  localparam int CNT_W = $clog2(STRETCH + 1);

  logic [NUM_CAUSES-1:0] causeSync;
  logic [CNT_W-1:0]      holdCnt;
  logic                  anyReq;
  logic                  inReset;

  rstagg_sync2 #(.WIDTH(NUM_CAUSES)) uSync (
    .clk  (clk),
    .arst (porReq),
    .dIn  (causeReq),
    .dOut (causeSync)
  );

  assign anyReq  = |causeSync;
  assign inReset = (holdCnt != '0);

  always_ff @(posedge clk or posedge porReq) begin
    if (porReq)                holdCnt <= CNT_W'(STRETCH);
    else if (anyReq)           holdCnt <= CNT_W'(STRETCH);
    else if (holdCnt != '0)    holdCnt <= holdCnt - 1'b1;
  end

  assign sysRst = porReq | inReset;

  always_comb begin
    strobes.setMask = '0;
    for (int i = 0; i < NUM_CAUSES; i++) begin
      if (causeSync[i]) strobes.setMask[CAUSE_BIT[i]] = 1'b1;
    end
    strobes.anyReq  = anyReq;
    strobes.coldReq = causeSync[BOR_IDX];
    strobes.inReset = inReset;
  end

  AST_REQ_RAISES_RST: assert property (@(posedge clk) disable iff (porReq)
    anyReq |=> sysRst); // R1
  AST_RELEASE_HELD: assert property (@(posedge clk) disable iff (porReq)
    $fell(anyReq) |-> sysRst); // R2
endmodule

// File: rtl/rstagg_dp.sv
module rstagg_dp
  import rstagg_pkg::*;
#(
  parameter int OSC_W = 3
) (
  input  logic              clk,
  input  logic              porReq,
  input  strobe_t           strobes,
  input  logic              wrEn,
  input  logic [STAT_W-1:0] wrData,
  input  logic [OSC_W-1:0]  cfgOscSel,
  input  logic [OSC_W-1:0]  curOscSel,
  output logic [STAT_W-1:0] status,
  output logic              coldReset,
  output logic [OSC_W-1:0]  clkSel
);
  always_ff @(posedge clk or posedge porReq) begin
    if (porReq) begin
      status    <= POR_STATUS;
      coldReset <= 1'b1;
    end else begin
      status <= (wrEn ? wrData : status) | strobes.setMask;
      if (strobes.coldReq)                        coldReset <= 1'b1;
      else if (strobes.anyReq && !strobes.inReset) coldReset <= 1'b0;
    end
  end

  always_comb clkSel = coldReset ? cfgOscSel : curOscSel;

  for (genvar b = 0; b < STAT_W; b++) begin : gStick
    AST_CAUSE_STICKS: assert property (@(posedge clk) disable iff (porReq)
      strobes.setMask[b] |=> status[b]); // R3
  end

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (porReq)
    (!wrEn && strobes.setMask == '0) |=> $stable(status)); // R5
  AST_COLD_ON_BOR: assert property (@(posedge clk) disable iff (porReq)
    strobes.coldReq |=> coldReset); // R7
  AST_WARM_FROM_IDLE: assert property (@(posedge clk) disable iff (porReq)
    (strobes.anyReq && !strobes.coldReq && !strobes.inReset) |=> !coldReset); // R8
  AST_COLD_KEPT: assert property (@(posedge clk) disable iff (porReq)
    (coldReset && strobes.inReset) |=> coldReset); // R9
endmodule

// File: rtl/reset_cause_hub.sv
module reset_cause_hub
  import rstagg_pkg::*;
#(
  parameter int STRETCH = 4,
  parameter int OSC_W   = 3
) (
  input  logic              clk,
  input  logic              porReq,
  input  logic              borReq,
  input  logic              mclrReq,
  input  logic              swResetReq,
  input  logic              wdtReq,
  input  logic              cfgMismatchReq,
  input  logic              trapReq,
  input  logic              illOpcodeReq,
  input  logic              uninitRegReq,
  input  logic              securityReq,
  input  logic              wrEn,
  input  logic [STAT_W-1:0] wrData,
  output logic [STAT_W-1:0] rdData,
  input  logic [OSC_W-1:0]  cfgOscSel,
  input  logic [OSC_W-1:0]  curOscSel,
  output logic [OSC_W-1:0]  clkSel,
  output logic              coldReset,
  output logic              sysRst
);
  logic [NUM_CAUSES-1:0] causeReq;
  strobe_t               strobes;

  assign causeReq = {securityReq, uninitRegReq, illOpcodeReq, trapReq,
                     cfgMismatchReq, wdtReq, swResetReq, mclrReq, borReq};

  rstagg_ctrl #(.STRETCH(STRETCH)) uCtrl (
    .clk      (clk),
    .porReq   (porReq),
    .causeReq (causeReq),
    .strobes  (strobes),
    .sysRst   (sysRst)
  );

  rstagg_dp #(.OSC_W(OSC_W)) uDp (
    .clk       (clk),
    .porReq    (porReq),
    .strobes   (strobes),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .cfgOscSel (cfgOscSel),
    .curOscSel (curOscSel),
    .status    (rdData),
    .coldReset (coldReset),
    .clkSel    (clkSel)
  );

  AST_WRITE_NO_RESET: assert property (@(posedge clk) disable iff (porReq)
    (wrEn && !sysRst && !strobes.anyReq) |=> !sysRst); // R6
endmodule

// File: tb/tb_reset_cause_hub.sv
module tb_reset_cause_hub;
  localparam int STRETCH = 4;
  localparam int OSC_W   = 3;

  logic clk = 1'b0;
  logic porReq = 1'b1;
  logic [8:0] cause = '0;
  logic wrEn = 1'b0;
  logic [9:0] wrData = '0;
  logic [9:0] rdData;
  logic [OSC_W-1:0] cfgOscSel = 3'd2;
  logic [OSC_W-1:0] curOscSel = 3'd5;
  logic [OSC_W-1:0] clkSel;
  logic coldReset, sysRst;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  reset_cause_hub #(.STRETCH(STRETCH), .OSC_W(OSC_W)) dut (
    .clk(clk), .porReq(porReq),
    .borReq(cause[0]), .mclrReq(cause[1]), .swResetReq(cause[2]),
    .wdtReq(cause[3]), .cfgMismatchReq(cause[4]), .trapReq(cause[5]),
    .illOpcodeReq(cause[6]), .uninitRegReq(cause[7]), .securityReq(cause[8]),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .cfgOscSel(cfgOscSel), .curOscSel(curOscSel), .clkSel(clkSel),
    .coldReset(coldReset), .sysRst(sysRst)
  );

  // status bit for each cause input, taken from the bit map in R3
  function automatic int expBit(int idx);
    case (idx)
      0: return 1;  1: return 7;  2: return 6;  3: return 4;  4: return 5;
      5: return 8;  6: return 2;  7: return 3;  default: return 9;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitEdges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic swWrite(logic [9:0] v);
    @(negedge clk);
    wrEn = 1'b1; wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseCause(int idx);
    @(negedge clk);
    cause[idx] = 1'b1;
    waitEdges(4);
    cause[idx] = 1'b0;
    waitEdges(STRETCH + 4);
  endtask

  task automatic testPowerOn();
    @(negedge clk);
    porReq = 1'b1;
    #1;
    chk("R4 async sysRst", 32'(sysRst), 1);
    chk("R4 status", 32'(rdData), 32'h003);
    chk("R7 por cold", 32'(coldReset), 1);
    chk("R7 por clkSel", 32'(clkSel), 32'(cfgOscSel));
    @(negedge clk);
    porReq = 1'b0;
    waitEdges(STRETCH - 1);
    chk("R4 hold after release", 32'(sysRst), 1);
    waitEdges(1);
    chk("R4 release", 32'(sysRst), 0);
    chk("R10 rdData after por", 32'(rdData), 32'h003);
  endtask

  task automatic testEachCause();
    for (int idx = 0; idx < 9; idx++) begin
      swWrite(10'h000);
      chk("R6 clear", 32'(rdData), 0);
      cause[idx] = 1'b1;
      waitEdges(2);
      chk("R1 not yet", 32'(sysRst), 0);
      waitEdges(1);
      chk("R1 asserted", 32'(sysRst), 1);
      waitEdges(3);
      cause[idx] = 1'b0;
      waitEdges(STRETCH + 1);
      chk("R2 still held", 32'(sysRst), 1);
      waitEdges(1);
      chk("R2 released", 32'(sysRst), 0);
      chk("R3 status bit", 32'(rdData), 32'(1) << expBit(idx));
      chk("R7/R8 cold flag", 32'(coldReset), (idx == 0) ? 1 : 0);
    end
  endtask

  task automatic testSticky();
    swWrite(10'h000);
    pulseCause(3);
    pulseCause(1);
    chk("R5 two sticky bits", 32'(rdData), 32'h090);
    pulseCause(8);
    chk("R5 three sticky bits", 32'(rdData), 32'h290);
  endtask

  task automatic testSoftwareWrite();
    logic coldBefore;
    coldBefore = coldReset;
    swWrite(10'h3C5);
    chk("R6 write value", 32'(rdData), 32'h3C5);
    waitEdges(6);
    chk("R6 no reset from write", 32'(sysRst), 0);
    chk("R6 cold unchanged", 32'(coldReset), 32'(coldBefore));
    swWrite(10'h000);
    chk("R6 clear all", 32'(rdData), 0);
    // cause active in the same cycle as a clearing write
    cause[3] = 1'b1;
    waitEdges(4);
    chk("R6 reset active", 32'(sysRst), 1);
    swWrite(10'h200);
    chk("R6 cause wins over write", 32'(rdData), 32'h210);
    cause[3] = 1'b0;
    waitEdges(STRETCH + 4);
  endtask

  task automatic testClockSelect();
    cfgOscSel = 3'd2; curOscSel = 3'd5;
    pulseCause(0);
    chk("R7 bor cold", 32'(coldReset), 1);
    chk("R7 bor clkSel", 32'(clkSel), 2);
    pulseCause(2);
    chk("R8 sw warm", 32'(coldReset), 0);
    chk("R8 sw clkSel", 32'(clkSel), 5);
    curOscSel = 3'd6;
    #1;
    chk("R8 follows running osc", 32'(clkSel), 6);
  endtask

  task automatic testWarmDuringCold();
    @(negedge clk);
    cause[0] = 1'b1;
    waitEdges(4);
    cause[3] = 1'b1;
    waitEdges(1);
    cause[0] = 1'b0;
    waitEdges(6);
    chk("R9 still in reset", 32'(sysRst), 1);
    cause[3] = 1'b0;
    waitEdges(STRETCH + 4);
    chk("R9 stays cold", 32'(coldReset), 1);
    chk("R9 clkSel cold", 32'(clkSel), 2);
    chk("R5 both bits", 32'(rdData) & 32'h012, 32'h012);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R4 reset status", 32'(rdData), 32'h003);
    chk("R4 reset sysRst", 32'(sysRst), 1);
    porReq = 1'b0;
    waitEdges(STRETCH + 2);
    testPowerOn();
    testEachCause();
    testSticky();
    testSoftwareWrite();
    testClockSelect();
    testWarmDuringCold();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule